// File: doc/BRIEF.md
# Stereo Channel Router with Raised-Cosine Soft Mute

This block sits in a digital audio path and handles one stereo sample pair per strobe. For each output channel it picks a source from the incoming pair: the left input, the right input, or the average of the two. It can also take a channel out of the mix. Muting is never abrupt. The channel's gain falls to zero through a raised-cosine sequence of coefficients, and on release it climbs back along the same sequence, run the other way.

Two control sources are possible. In static mode the routing is fixed (left to left, right to right) and each channel has its own mute pin. In register mode each channel takes a 2-bit routing code, and code 00 asks for that channel to be muted. Each channel has its own ramp position, so one side can fade while the other plays at full level. All changes take effect only on accepted samples.

Top module: `chmap_softmute`

## Requirements
- R1: A sample accepted with `in_valid` appears on `out_left`/`out_right` one clock later with `out_valid` high. `out_valid` is low in every other cycle, and the outputs hold their values between samples.
- R2: In register mode (`reg_mode`=1) a channel's code selects its source: 01 = right input, 10 = left input, 11 = floor((left+right)/2) formed at 21 bits. With the ramp at rest, the output equals that source bit for bit.
- R3: In static mode (`reg_mode`=0) the left output takes the left input and the right output takes the right input, whatever the codes. Each channel is muted by its own pin. In register mode the pins have no effect.
- R4: Each channel has a ramp position from 0 to 1024. On every accepted sample the position rises by one while a mute is requested (saturating at 1024) and falls by one otherwise (saturating at 0). The two channels' positions are independent.
- R5: The ramp coefficients c[k] for k=0..31 are unsigned, with 32768 representing 1.0. With S=32, m=|S-2(k+1)|, q=m(2S-m), N=16q and D=20S^2-4q: c[k] = floor(32768(D+N)/(2D)) when S >= 2(k+1), and floor(32768(D-N)/(2D)) otherwise. This gives a falling raised-cosine curve with c[31]=0.
- R6: At position p>0 the output is (x*c[(p-1)/32] + 16384) >>> 15 on the 20-bit signed source x. Each coefficient is therefore used for 32 consecutive samples.
- R7: At position 1024, which is reached on the 1024th consecutive muted sample, the output is exactly zero.
- R8: Releasing a mute walks the positions back down from wherever the ramp stands, with no jump. A full release therefore repeats the mute outputs in reverse order, and the gain returns to exact full level on the 1024th released sample.
- R9: While a channel is muted by code 00, it keeps the source chosen by its most recent nonzero code. After reset that source is left for the left channel and right for the right channel.
- R10: After reset `out_valid` is low, both outputs are zero and both ramps are at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 20 | Left input sample, signed |
| in_right | input | 20 | Right input sample, signed |
| reg_mode | input | 1 | 1 = register routing codes, 0 = static routing with mute pins |
| map_left | input | 2 | Routing code for the left output |
| map_right | input | 2 | Routing code for the right output |
| mute_pin_left | input | 1 | Static-mode mute request, left |
| mute_pin_right | input | 1 | Static-mode mute request, right |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 20 | Left output sample, signed |
| out_right | output | 20 | Right output sample, signed |

## Verification
Random sample pairs are routed under every code combination, together with full-scale and most-negative inputs. Equal extreme inputs show whether the average is formed wide enough to avoid wrap. A constant full-scale input held through a complete mute shows where each 32-sample hold ends and confirms the exact zero at the end of the ramp. The same input through the release that follows shows whether the output retraces the mute sequence in mirror order. A mute cut short and reversed after 100 samples separates a reversal that continues from the current position from one that restarts. Mixed random runs that toggle modes, pins and code 00 set the static path against the register path, and check that a muted channel keeps its previously selected source.

// File: rtl/chmap_pkg.sv
package chmap_pkg;

    localparam int SMP_W      = 20;
    localparam int RAMP_STEPS = 32;
    localparam int RAMP_HOLD  = 32;
    localparam int COEF_FRAC  = 15;

    typedef enum logic [1:0] {
        MAP_MUTE  = 2'b00,
        MAP_RIGHT = 2'b01,
        MAP_LEFT  = 2'b10,
        MAP_MONO  = 2'b11
    } map_e;

    // Raised-cosine gain for ramp step k, built from an integer sine
    // approximation so that it stays a pure constant function.
    function automatic longint ramp_coef(input int k, input int steps, input int frac);
        longint span, ofs, mag, prod, numer, denom, unity;
        span  = 2 * longint'(steps);
        ofs   = longint'(steps) - 2 * (longint'(k) + 1);
        mag   = (ofs < 0) ? -ofs : ofs;
        prod  = mag * (span - mag);
        numer = 16 * prod;
        denom = 5 * span * span - 4 * prod;
        unity = longint'(1) << frac;
        if (ofs >= 0)
            return (unity * (denom + numer)) / (2 * denom);
        return (unity * (denom - numer)) / (2 * denom);
    endfunction

endpackage

// File: rtl/chmap_route.sv
module chmap_route
    import chmap_pkg::*;
#(
    parameter int W        = SMP_W,
    parameter bit IS_RIGHT = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic                reg_mode,
    input  logic [1:0]          code,
    input  logic                pin_mute,
    input  logic signed [W-1:0] left,
    input  logic signed [W-1:0] right,
    output logic signed [W-1:0] smp,
    output logic                mute
);

    localparam map_e HOME = IS_RIGHT ? MAP_RIGHT : MAP_LEFT;

    map_e held_q;
    map_e code_e;
    map_e pick;
    logic signed [W:0] pair_sum;

    always_comb begin
        code_e = map_e'(code);
        if (!reg_mode) begin
            pick = HOME;
            mute = pin_mute;
        end else begin
            mute = (code_e == MAP_MUTE);
            pick = mute ? held_q : code_e;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= HOME;
        else if (step && reg_mode && code_e != MAP_MUTE)
            held_q <= code_e;
    end

    assign pair_sum = {left[W-1], left} + {right[W-1], right};

    always_comb begin
        case (pick)
            MAP_RIGHT: smp = right;
            MAP_LEFT:  smp = left;
            MAP_MONO:  smp = pair_sum[W:1];
            default:   smp = left;
        endcase
    end

endmodule

// File: rtl/chmap_ramp.sv
module chmap_ramp #(
    parameter int STEPS = 32,
    parameter int HOLD  = 32,
    parameter int PW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          mute,
    output logic [PW-1:0] pos_nxt,
    output logic [PW-1:0] pos_q
);

    localparam int            LEN   = STEPS * HOLD;
    localparam logic [PW-1:0] LEN_P = PW'(LEN);

    always_comb begin
        pos_nxt = pos_q;
        if (step) begin
            if (mute && pos_q != LEN_P)
                pos_nxt = pos_q + 1'b1;
            else if (!mute && pos_q != '0)
                pos_nxt = pos_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else
            pos_q <= pos_nxt;
    end

endmodule

// File: rtl/chmap_gain.sv
module chmap_gain
    import chmap_pkg::*;
#(
    parameter int W     = SMP_W,
    parameter int STEPS = RAMP_STEPS,
    parameter int HOLD  = RAMP_HOLD,
    parameter int CF    = COEF_FRAC,
    parameter int PW    = 11
) (
    input  logic signed [W-1:0] x,
    input  logic [PW-1:0]       pos,
    output logic signed [W-1:0] y
);

    localparam int KW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int MW = W + CF + 2;
    localparam logic signed [MW-1:0] HALF_LSB = MW'(longint'(1) << (CF - 1));

    logic [CF:0] rom [STEPS];

    for (genvar k = 0; k < STEPS; k++) begin : g_rom
        localparam longint COEF = ramp_coef(k, STEPS, CF);
        assign rom[k] = (CF + 1)'(COEF);
    end

    logic [PW-1:0]          below;
    logic [KW-1:0]          idx;
    logic signed [MW-1:0]   prod;
    logic signed [MW-1:0]   rounded;

    always_comb begin
        below   = pos - 1'b1;
        idx     = KW'(below / PW'(HOLD));
        prod    = x * $signed({1'b0, rom[idx]});
        rounded = prod + HALF_LSB;
        if (pos == '0)
            y = x;
        else
            y = $signed(W'(rounded >>> CF));
    end

endmodule

// File: rtl/chmap_softmute.sv
module chmap_softmute
    import chmap_pkg::*;
#(
    parameter int W     = SMP_W,
    parameter int STEPS = RAMP_STEPS,
    parameter int HOLD  = RAMP_HOLD,
    parameter int CF    = COEF_FRAC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_left,
    input  logic signed [W-1:0] in_right,
    input  logic                reg_mode,
    input  logic [1:0]          map_left,
    input  logic [1:0]          map_right,
    input  logic                mute_pin_left,
    input  logic                mute_pin_right,
    output logic                out_valid,
    output logic signed [W-1:0] out_left,
    output logic signed [W-1:0] out_right
);

    localparam int LEN = STEPS * HOLD;
    localparam int PW  = $clog2(LEN + 1);

    logic signed [W-1:0] src    [2];
    logic signed [W-1:0] gained [2];
    logic                mreq   [2];
    logic [PW-1:0]       pnxt   [2];
    logic [PW-1:0]       pcur   [2];
    logic [PW-1:0]       pos_left;
    logic [PW-1:0]       pos_right;

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        chmap_route #(.W(W), .IS_RIGHT(ch == 1)) u_route (
            .clk      (clk),
            .rst      (rst),
            .step     (in_valid),
            .reg_mode (reg_mode),
            .code     ((ch == 1) ? map_right : map_left),
            .pin_mute ((ch == 1) ? mute_pin_right : mute_pin_left),
            .left     (in_left),
            .right    (in_right),
            .smp      (src[ch]),
            .mute     (mreq[ch])
        );

        chmap_ramp #(.STEPS(STEPS), .HOLD(HOLD), .PW(PW)) u_ramp (
            .clk     (clk),
            .rst     (rst),
            .step    (in_valid),
            .mute    (mreq[ch]),
            .pos_nxt (pnxt[ch]),
            .pos_q   (pcur[ch])
        );

        chmap_gain #(.W(W), .STEPS(STEPS), .HOLD(HOLD), .CF(CF), .PW(PW)) u_gain (
            .x   (src[ch]),
            .pos (pnxt[ch]),
            .y   (gained[ch])
        );
    end

    assign pos_left  = pcur[0];
    assign pos_right = pcur[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= gained[0];
                out_right <= gained[1];
            end
        end
    end

endmodule

// File: rtl/chmap_checker.sv
module chmap_checker #(
    parameter int W   = 20,
    parameter int PW  = 11,
    parameter int LEN = 1024
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                reg_mode,
    input logic [1:0]          map_left,
    input logic signed [W-1:0] in_left,
    input logic                out_valid,
    input logic signed [W-1:0] out_left,
    input logic signed [W-1:0] out_right,
    input logic [PW-1:0]       pos_left,
    input logic [PW-1:0]       pos_right
);

    localparam logic [PW-1:0] FULL_P = PW'(LEN);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_outputs_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));

    assert_passthrough_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && reg_mode && map_left == 2'b10 && pos_left == '0)
        |=> out_left == $past(in_left));

    assert_pos_still_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pos_left) && $stable(pos_right)));

    assert_pos_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((pos_left == $past(pos_left)) ||
                      (pos_left == $past(pos_left) + 1'b1) ||
                      (pos_left + 1'b1 == $past(pos_left))));

    assert_pos_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (pos_left <= FULL_P) && (pos_right <= FULL_P));

    assert_mute_zero_left_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos_left == FULL_P) |-> out_left == '0);

    assert_mute_zero_right_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos_right == FULL_P) |-> out_right == '0);

endmodule

bind chmap_softmute chmap_checker #(.W(W), .PW(PW), .LEN(LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .reg_mode  (reg_mode),
    .map_left  (map_left),
    .in_left   (in_left),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .pos_left  (pos_left),
    .pos_right (pos_right)
);

// File: tb/chmap_softmute_test.sv
`timescale 1ns/1ps
module chmap_softmute_test;

    localparam int  LEN  = 1024;
    localparam int  HOLD = 32;
    localparam logic signed [19:0] MAXP = 20'sh7FFFF;
    localparam logic signed [19:0] MAXN = 20'sh80000;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic signed [19:0] in_left, in_right;
    logic reg_mode;
    logic [1:0] map_left, map_right;
    logic mute_pin_left, mute_pin_right;
    logic out_valid;
    logic signed [19:0] out_left, out_right;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int pos_m  [2];
    int held_m [2];
    longint exp_o [2];
    longint vm [1025];

    always #2 clk = ~clk;

    chmap_softmute uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .reg_mode(reg_mode), .map_left(map_left), .map_right(map_right),
        .mute_pin_left(mute_pin_left), .mute_pin_right(mute_pin_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic longint b_coef(int k);
        longint two_s, off, a, q, nn, dd;
        two_s = 64;
        off   = 32 - 2 * (k + 1);
        a     = (off < 0) ? -off : off;
        q     = a * (two_s - a);
        nn    = 16 * q;
        dd    = 5 * two_s * two_s - 4 * q;
        if (off >= 0) return (32768 * (dd + nn)) / (2 * dd);
        return (32768 * (dd - nn)) / (2 * dd);
    endfunction

    function automatic longint b_gain(longint x, int p);
        longint v;
        if (p == 0) return x;
        v = x * b_coef((p - 1) / HOLD) + 16384;
        v = v >>> 15;
        return v;
    endfunction

    function automatic logic signed [19:0] rnd20();
        return 20'($urandom);
    endfunction

    task automatic chk(string req, longint act, longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic send(input logic signed [19:0] l, input logic signed [19:0] r,
                        input logic [1:0] ml, input logic [1:0] mr,
                        input logic mode, input logic pl, input logic pr);
        string tag [2];
        @(negedge clk);
        chk("R1 idle strobe", longint'(out_valid), 0);
        in_left = l; in_right = r; map_left = ml; map_right = mr;
        reg_mode = mode; mute_pin_left = pl; mute_pin_right = pr;
        in_valid = 1'b1;
        for (int ch = 0; ch < 2; ch++) begin
            int code, srcsel;
            bit mu;
            longint x;
            code = (ch == 1) ? int'(mr) : int'(ml);
            if (mode) begin
                mu     = (code == 0);
                srcsel = mu ? held_m[ch] : code;
                if (!mu) held_m[ch] = code;
            end else begin
                mu     = (ch == 1) ? pr : pl;
                srcsel = (ch == 1) ? 1 : 2;
            end
            if (srcsel == 1)      x = longint'(r);
            else if (srcsel == 2) x = longint'(l);
            else                  x = (longint'(l) + longint'(r)) >>> 1;
            if (mu && pos_m[ch] < LEN) pos_m[ch]++;
            else if (!mu && pos_m[ch] > 0) pos_m[ch]--;
            exp_o[ch] = b_gain(x, pos_m[ch]);
            if (pos_m[ch] == LEN)           tag[ch] = "R7 zero when muted";
            else if (mode && code == 0)     tag[ch] = "R9 held source ramp";
            else if (pos_m[ch] > 0)         tag[ch] = "R6 ramp gain";
            else if (!mode)                 tag[ch] = "R3 static routing";
            else                            tag[ch] = "R2 code routing";
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 output strobe", longint'(out_valid), 1);
        chk({tag[0], " left"},  longint'(out_left),  exp_o[0]);
        chk({tag[1], " right"}, longint'(out_right), exp_o[1]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; in_valid = 1'b0; in_left = '0; in_right = '0;
        reg_mode = 1'b0; map_left = 2'b10; map_right = 2'b01;
        mute_pin_left = 1'b0; mute_pin_right = 1'b0;
        pos_m[0] = 0; pos_m[1] = 0; held_m[0] = 2; held_m[1] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset strobe", longint'(out_valid), 0);
        chk("R10 reset left",   longint'(out_left), 0);
        chk("R10 reset right",  longint'(out_right), 0);

        // R3: static routing, codes ignored
        for (int i = 0; i < 40; i++)
            send(rnd20(), rnd20(), 2'($urandom), 2'($urandom), 1'b0, 1'b0, 1'b0);

        // R2: register routing with every nonzero code, pins ignored
        for (int i = 0; i < 200; i++)
            send(rnd20(), rnd20(), 2'(1 + $urandom % 3), 2'(1 + $urandom % 3),
                 1'b1, 1'($urandom), 1'($urandom));
        send(MAXP, MAXP, 2'b11, 2'b11, 1'b1, 1'b0, 1'b0);
        chk("R2 mono at positive extreme", longint'(out_left), longint'(MAXP));
        send(MAXN, MAXN, 2'b11, 2'b11, 1'b1, 1'b0, 1'b0);
        chk("R2 mono at negative extreme", longint'(out_right), longint'(MAXN));
        send(MAXP, MAXN, 2'b11, 2'b10, 1'b1, 1'b0, 1'b0);
        chk("R2 mono of opposite extremes", longint'(out_left), -1);
        send(rnd20(), rnd20(), 2'b10, 2'b01, 1'b1, 1'b0, 1'b0);

        // Full mute of left, constant full-scale input
        for (int j = 1; j <= LEN + 40; j++) begin
            send(MAXP, rnd20(), 2'b00, 2'(1 + $urandom % 3), 1'b1, 1'b0, 1'b0);
            if (j <= LEN) vm[j] = longint'(out_left);
            if (j == 1)   chk("R5 first coefficient", longint'(out_left),
                              (longint'(MAXP) * b_coef(0) + 16384) >>> 15);
            if (j == 32)  chk("R4 hold of first step", longint'(out_left), vm[1]);
            if (j == 33)  chk("R4 next step after hold", longint'(out_left),
                              (longint'(MAXP) * b_coef(1) + 16384) >>> 15);
            if (j == 992) chk("R5 last nonzero step", longint'(out_left),
                              (longint'(MAXP) * b_coef(30) + 16384) >>> 15);
            if (j == LEN) chk("R7 ramp ends at zero", longint'(out_left), 0);
            if (j == 100) chk("R4 right channel independent", longint'(out_right), exp_o[1]);
        end

        // Full release: mirror order of the mute
        for (int j = 1; j <= LEN + 20; j++) begin
            send(MAXP, rnd20(), 2'b10, 2'(1 + $urandom % 3), 1'b1, 1'b0, 1'b0);
            if (j < LEN)  chk("R8 release mirrors mute", longint'(out_left), vm[LEN - j]);
            if (j == LEN) chk("R8 full gain restored", longint'(out_left), longint'(MAXP));
        end

        // Mid-ramp reversal on right, muted by code 00 while holding left source
        send(MAXP, rnd20(), 2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
        for (int j = 1; j <= 100; j++) begin
            send(MAXP, rnd20(), 2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
            if (j == 99) vm[0] = longint'(out_right);
        end
        chk("R9 muted channel keeps left source", longint'(out_right),
            (longint'(MAXP) * b_coef(3) + 16384) >>> 15);
        for (int j = 1; j <= 150; j++) begin
            send(MAXP, rnd20(), 2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
            if (j == 1) chk("R8 reversal continues from current step",
                            longint'(out_right), vm[0]);
        end

        // R3: static mute pin on right, codes ignored
        for (int j = 1; j <= LEN + 30; j++)
            send(rnd20(), rnd20(), 2'($urandom), 2'($urandom), 1'b0, 1'b0, 1'b1);
        chk("R3 static pin mute reaches zero", longint'(out_right), 0);
        for (int j = 1; j <= 200; j++)
            send(rnd20(), rnd20(), 2'($urandom), 2'($urandom), 1'b0, 1'b0, 1'b0);

        // Mixed random traffic
        begin
            logic md, pl, pr;
            logic [1:0] cl, cr;
            md = 1'b1; pl = 1'b0; pr = 1'b0; cl = 2'b10; cr = 2'b01;
            for (int j = 0; j < 1500; j++) begin
                if ($urandom % 200 == 0) md = ~md;
                if ($urandom % 60 == 0)  pl = ~pl;
                if ($urandom % 60 == 0)  pr = ~pr;
                if ($urandom % 40 == 0)  cl = 2'($urandom);
                if ($urandom % 40 == 0)  cr = 2'($urandom);
                send(rnd20(), rnd20(), cl, cr, md, pl, pr);
            end
        end

        done = 1;
        finish_run();
    end

endmodule